// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block turns an oscillator clock into a repeating four-phase instruction cycle and runs a two-stage pipeline on it. One cycle fetches an instruction while the next one executes. The block owns the program counter and drives it onto the program-memory address. It samples the returned 14-bit word late in the cycle and shows that word as the executing instruction for the whole following cycle. It also marks the operand-read phase and the result-write phase for the data memory.

The execute stage can ask for a jump during the third phase. The block then loads the target into the program counter. It discards the word that was already fetched and runs one flushed no-op cycle while the target word is fetched. In that flushed cycle the write strobe stays low. A divided clock at one quarter of the oscillator rate is provided for outside logic. Decode, the ALU, the register file and the call stack sit outside this block.

Top module: `qcycle_seq`

## Requirements
- R1: `phase_oh` is one-hot and rotates Q1 (bit 0), Q2 (bit 1), Q3 (bit 2), Q4 (bit 3), then back to Q1, advancing once per oscillator clock. Reset puts it in Q1.
- R2: `clk_div` is high while the phase is Q1 or Q2, and low while it is Q3 or Q4.
- R3: `pm_addr` changes only when a Q1 phase begins. Without a jump it becomes the previous value plus one.
- R4: `pm_rdata` is sampled during Q3 of the cycle that shows the address. The sampled word appears on `ir_word` from the next Q1 to the end of that next cycle.
- R5: `dm_rd_stb` is high exactly during Q2 of every cycle.
- R6: `dm_wr_stb` is high exactly during Q4 of every cycle in which `flush` is low.
- R7: If `br_req` is high during Q3 of a cycle with `flush` low, `br_target` is sampled. The next cycle then shows `pm_addr` = target, `ir_word` = 0 (the no-op) and `flush` = 1. The cycle after that executes the word at the target, with `pm_addr` = target + 1.
- R8: `br_req` has no effect when it is high in Q1, Q2 or Q4, or in any phase of a cycle with `flush` high.
- R9: After a synchronous reset, `pm_addr` is 0, `ir_word` is 0 and `flush` is 1 for the first cycle. The word at address 0 executes in the second cycle.
- R10: The program counter wraps from 1023 to 0 when it increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_oh | output | 4 | One-hot phase, bit 0 = Q1 ... bit 3 = Q4 |
| clk_div | output | 1 | Quarter-rate clock, high in Q1/Q2 |
| pm_addr | output | 10 | Program-memory fetch address (program counter) |
| pm_rdata | input | 14 | Program-memory word, sampled in Q3 |
| ir_word | output | 14 | Instruction in the execute stage |
| flush | output | 1 | Execute stage holds a discarded word (no-op) |
| br_req | input | 1 | Jump request from the execute stage, sampled in Q3 |
| br_target | input | 10 | Jump target address |
| dm_rd_stb | output | 1 | Data-memory operand read strobe (Q2) |
| dm_wr_stb | output | 1 | Data-memory result write strobe (Q4, not in flush) |

## Verification
Two things can land on the same Q1 edge. One is a jump that takes effect. The other is the normal increment, including the wrap from 1023 to 0. A second kind of overlap is a new jump request arriving inside the flushed cycle of a previous jump. The bench drives jump requests in every phase from a pseudo-random pattern. It also aims one jump just below the top of the address space, so that the wrap follows a jump closely. A behavioural model judges every clock on the address, the instruction word, `flush` and both strobes. An ignored request shows up at once as a wrong `pm_addr` or a missing flush.

// File: rtl/qcyc_pkg.sv
package qcyc_pkg;
  typedef enum logic [1:0] {PH_Q1 = 2'd0, PH_Q2 = 2'd1, PH_Q3 = 2'd2, PH_Q4 = 2'd3} phase_e;
  localparam int NUM_PHASES = 4;
endpackage

// File: rtl/qcyc_phase_gen.sv
module qcyc_phase_gen
  import qcyc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  output logic [NUM_PHASES-1:0] ring,
  output logic                  clk_div,
  output logic                  rd_slot,
  output logic                  wr_slot
);
  logic [NUM_PHASES-1:0] ring_nx;

  always_comb ring_nx = {ring[NUM_PHASES-2:0], ring[NUM_PHASES-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ring    <= NUM_PHASES'(1);
      clk_div <= 1'b1;
      rd_slot <= 1'b0;
      wr_slot <= 1'b0;
    end else begin
      ring    <= ring_nx;
      clk_div <= ring_nx[PH_Q1] | ring_nx[PH_Q2];
      rd_slot <= ring_nx[PH_Q2];
      wr_slot <= ring_nx[PH_Q4];
    end
  end

  // R1: exactly one phase active
  p_ring_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(ring) == 1);
  // R1: Q4 is followed by Q1
  p_ring_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    ring[PH_Q4] |=> ring[PH_Q1]);
  // R2: divided clock tracks the first half of the cycle
  p_clkdiv_r2: assert property (@(posedge clk) disable iff (rst)
    clk_div == (ring[PH_Q1] | ring[PH_Q2]));
  // R5: read strobe only in Q2
  p_rd_in_q2_r5: assert property (@(posedge clk) disable iff (rst)
    rd_slot == ring[PH_Q2]);
endmodule

// File: rtl/qcyc_pc_unit.sv
module qcyc_pc_unit #(
  parameter int PC_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            at_q3,
  input  logic            at_q4,
  input  logic            flush,
  input  logic            br_req,
  input  logic [PC_W-1:0] br_target,
  output logic [PC_W-1:0] pc,
  output logic            jump_pend
);
  logic [PC_W-1:0] tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      tgt_q     <= '0;
      jump_pend <= 1'b0;
    end else begin
      if (at_q3) begin
        jump_pend <= br_req & ~flush;
        tgt_q     <= br_target;
      end else if (at_q4) begin
        jump_pend <= 1'b0;
      end
      if (at_q4) pc <= jump_pend ? tgt_q : pc + 1'b1;
    end
  end

  // R3: PC only moves on entry to Q1
  p_pc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !at_q4 |=> $stable(pc));
  // R3 / R10: plain increment with wrap
  p_pc_incr_r10: assert property (@(posedge clk) disable iff (rst)
    (at_q4 && !jump_pend) |=> pc == PC_W'($past(pc) + 1'b1));
  // R7: taken jump loads the sampled target
  p_pc_jump_r7: assert property (@(posedge clk) disable iff (rst)
    (at_q4 && jump_pend) |=> pc == $past(tgt_q));
  // R8: no jump is armed from a flushed cycle
  p_no_arm_in_flush_r8: assert property (@(posedge clk) disable iff (rst)
    (at_q3 && flush) |=> !jump_pend);
endmodule

// File: rtl/qcyc_fetch_pipe.sv
module qcyc_fetch_pipe #(
  parameter int               WORD_W   = 14,
  parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              at_q3,
  input  logic              at_q4,
  input  logic              jump_pend,
  input  logic [WORD_W-1:0] pm_rdata,
  output logic [WORD_W-1:0] ir,
  output logic              flush
);
  logic [WORD_W-1:0] fetch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_q <= NOP_WORD;
      ir      <= NOP_WORD;
      flush   <= 1'b1;
    end else begin
      if (at_q3) fetch_q <= pm_rdata;
      if (at_q4) begin
        ir    <= jump_pend ? NOP_WORD : fetch_q;
        flush <= jump_pend;
      end
    end
  end

  // R4: executing word stays put inside an instruction cycle
  p_ir_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !at_q4 |=> ($stable(ir) && $stable(flush)));
  // R7: a flushed cycle executes the no-op
  p_flush_nop_r7: assert property (@(posedge clk) disable iff (rst)
    flush |-> ir == NOP_WORD);
endmodule

// File: rtl/qcycle_seq.sv
module qcycle_seq
  import qcyc_pkg::*;
#(
  parameter int                PC_W     = 10,
  parameter int                WORD_W   = 14,
  parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [3:0]        phase_oh,
  output logic              clk_div,
  output logic [PC_W-1:0]   pm_addr,
  input  logic [WORD_W-1:0] pm_rdata,
  output logic [WORD_W-1:0] ir_word,
  output logic              flush,
  input  logic              br_req,
  input  logic [PC_W-1:0]   br_target,
  output logic              dm_rd_stb,
  output logic              dm_wr_stb
);
  logic [NUM_PHASES-1:0] ring;
  logic                  wr_slot;
  logic                  jump_pend;
  logic                  flush_q;

  qcyc_phase_gen u_phase (
    .clk     (clk),
    .rst     (rst),
    .ring    (ring),
    .clk_div (clk_div),
    .rd_slot (dm_rd_stb),
    .wr_slot (wr_slot)
  );

  qcyc_pc_unit #(.PC_W(PC_W)) u_pc (
    .clk       (clk),
    .rst       (rst),
    .at_q3     (ring[PH_Q3]),
    .at_q4     (ring[PH_Q4]),
    .flush     (flush_q),
    .br_req    (br_req),
    .br_target (br_target),
    .pc        (pm_addr),
    .jump_pend (jump_pend)
  );

  qcyc_fetch_pipe #(.WORD_W(WORD_W), .NOP_WORD(NOP_WORD)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .at_q3     (ring[PH_Q3]),
    .at_q4     (ring[PH_Q4]),
    .jump_pend (jump_pend),
    .pm_rdata  (pm_rdata),
    .ir        (ir_word),
    .flush     (flush_q)
  );

  assign phase_oh  = ring;
  assign flush     = flush_q;
  assign dm_wr_stb = wr_slot & ~flush_q;

  // R6: no destination write while a discarded word executes
  p_no_wr_in_flush_r6: assert property (@(posedge clk) disable iff (rst)
    flush |-> !dm_wr_stb);
  // R6: write strobe only in Q4
  p_wr_in_q4_r6: assert property (@(posedge clk) disable iff (rst)
    dm_wr_stb |-> phase_oh[PH_Q4]);
endmodule

// File: tb/qcycle_seq_bench.sv
`timescale 1ns/1ps
module qcycle_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  phase_oh;
  logic        clk_div, flush, dm_rd_stb, dm_wr_stb;
  logic [9:0]  pm_addr;
  logic [13:0] pm_rdata, ir_word;
  logic        br_req = 1'b0;
  logic [9:0]  br_target = '0;

  always #4 clk = ~clk;

  function automatic logic [13:0] memf(input logic [9:0] a);
    return 14'((a * 37 + 5) ^ (a << 4)) | 14'h1;
  endfunction
  assign pm_rdata = memf(pm_addr);

  qcycle_seq u_qcycle_seq (
    .clk(clk), .rst(rst), .phase_oh(phase_oh), .clk_div(clk_div),
    .pm_addr(pm_addr), .pm_rdata(pm_rdata), .ir_word(ir_word), .flush(flush),
    .br_req(br_req), .br_target(br_target),
    .dm_rd_stb(dm_rd_stb), .dm_wr_stb(dm_wr_stb)
  );

  int compared = 0, mismatched = 0;
  int m_ph, m_pc, m_ir, m_fetch, m_tgt;
  bit m_flush, m_pend, live = 0, wrapped = 0;
  int cyc = 0, mode = 0;
  int unsigned lfsr = 32'h1234_5678;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_ph = 0; m_pc = 0; m_ir = 0; m_flush = 1; m_pend = 0; m_fetch = 0; m_tgt = 0;
    end else begin
      if (m_ph == 2) begin
        m_fetch = memf(10'(m_pc));
        m_pend  = br_req && !m_flush;
        m_tgt   = br_target;
      end else if (m_ph == 3) begin
        if (m_pend) begin m_pc = m_tgt; m_ir = 0; m_flush = 1; end
        else begin
          if (m_pc == 1023) wrapped = 1;
          m_pc = (m_pc + 1) % 1024; m_ir = m_fetch; m_flush = 0;
        end
        m_pend = 0;
      end
      m_ph = (m_ph + 1) % 4;
    end
  end

  // compare every cycle, then drive new stimulus
  always @(negedge clk) begin
    if (live) begin
      chk("R1 phase_oh",  phase_oh,  1 << m_ph);
      chk("R2 clk_div",   clk_div,   m_ph < 2);
      chk("R3/R7/R8/R10 pm_addr", pm_addr, m_pc);
      chk("R4/R7 ir_word", ir_word,  m_ir);
      chk("R7/R9 flush",  flush,     m_flush);
      chk("R5 dm_rd_stb", dm_rd_stb, m_ph == 1);
      chk("R6 dm_wr_stb", dm_wr_stb, (m_ph == 3) && !m_flush);
    end
    lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
    case (mode)
      1: begin br_req = (lfsr % 5) == 0; br_target = 10'(lfsr >> 8); end // R8: all phases
      2: begin br_req = 1'b1; br_target = 10'd1019; end                  // R10 approach
      default: begin br_req = 1'b0; br_target = 10'(lfsr >> 3); end
    endcase
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    live = 1;
    #1;
    // R9: reset state seen before the first free-running edge
    chk("R9 reset pm_addr", pm_addr, 0);
    chk("R9 reset ir_word", ir_word, 0);
    chk("R9 reset flush",   flush,   1);
    chk("R1 reset phase",   phase_oh, 1);
    repeat (40) @(posedge clk);
    mode = 1;
    repeat (800) @(posedge clk);
    mode = 0;
    repeat (20) @(posedge clk);
    mode = 2;
    repeat (12) @(posedge clk);
    mode = 0;
    repeat (60) @(posedge clk);
    @(negedge clk); #1;
    chk("R10 wrap observed", wrapped, 1);
    mode = 1;
    repeat (400) @(posedge clk);
    mode = 0;
    repeat (16) @(posedge clk);
    @(negedge clk); #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule